// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. A falling edge on the active-low start input clears any conversion in flight and loads the trial code with only its top bit set. On each following step the block samples a one-bit comparator result. A 1 means the analog input is at or above the trial code, so the trial bit is kept; a 0 clears it. The next lower bit is then tried. The trial code drives an external DAC. The comparator, DAC and reference sit outside the block.

The conversion can be cut short at 10 or 8 bits. Bits below the last resolved position are never trialled. Results use complemented coding. Each decision also leaves the block as a serial bit with a strobe, most significant bit first. When a conversion finishes, a status line drops and a 12-bit parallel register loads; it then holds until the next conversion completes. In external-clock mode the block steps only on start falling edges, so the start pin acts as the bit clock.

Top module: `sar_sequencer`

## Requirements
- R1: In internal-clock mode (extClkMode=0), a falling edge of startN seen at a clock edge restarts the sequence, even during a conversion. From that edge on, busy=1 and dacCode holds only bit 11 set (12'h800).
- R2: An N-bit conversion uses N+1 clock edges: the restart edge plus N decision edges. busy is high for exactly N clock periods and falls at the edge that decides the last bit.
- R3: done is a one-cycle pulse that is high in the same cycle busy first reads 0 after a conversion. result changes only in a cycle where done is 1.
- R4: At each decision edge, cmpHigh=1 keeps the current trial bit and cmpHigh=0 clears it. The next lower bit is then set in dacCode. With an ideal comparator (cmpHigh = input >= dacCode), the raw code equals the input truncated to its top N bits.
- R5: resSel selects N and is captured at the restart edge: 2'b00 and 2'b11 give 12 bits, 2'b01 gives 10 bits, 2'b10 gives 8 bits.
- R6: In a short-cycled conversion, bits below the last resolved bit are never set in dacCode. They therefore read as 1 in result after complementing.
- R7: result is the bitwise complement of the raw code. When bipolar=1 and twosComp=1, bit 11 of result equals raw bit 11 (complemented two's complement). Otherwise no bit is exempt.
- R8: Each decision raises serClk for one cycle, starting one edge after the decision. During that cycle serData carries the complement of the bit just decided. The N pulses of a conversion arrive MSB first.
- R9: In external-clock mode (extClkMode=1), a startN falling edge while idle starts a conversion. A falling edge while busy performs one decision step. Clock edges without a falling edge leave dacCode unchanged, so N+1 falling edges give one result.
- R10: result holds its value between done pulses, including while a restarted conversion runs. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startN | input | 1 | Start strobe; falling edge starts or steps a conversion |
| extClkMode | input | 1 | 1: startN supplies each bit step |
| resSel | input | 2 | Resolution select (00/11=12, 01=10, 10=8 bits) |
| bipolar | input | 1 | Bipolar coding select |
| twosComp | input | 1 | With bipolar, complemented two's complement coding |
| cmpHigh | input | 1 | Comparator: 1 when input is at or above the trial code |
| dacCode | output | 12 | Trial code to the DAC |
| busy | output | 1 | 1 during restart and conversion, 0 when complete |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Parallel result, held until the next completion |
| serData | output | 1 | NRZ serial decision, complemented, MSB first |
| serClk | output | 1 | One pulse per decided bit |

## Verification
A wrong step counter shows up in the first conversion. busy stays high one period too long or too short, and the serial strobe count no longer matches the selected resolution, both within N+1 cycles of start. A wrong trial mask or keep/clear decision corrupts dacCode on the next edge. The fault reaches the ports as a wrong serial bit one cycle later and as a wrong parallel word at done. A mishandled restart or external step appears as a trial code other than 12'h800 right after the falling edge, or as dacCode moving on an edge with no start pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic start;   // load top trial bit, clear previous trial
    logic decide;  // resolve current trial bit from comparator
    logic last;    // current decision is the final one
  } sarStrobe_t;
endpackage

// File: rtl/sar_fall_detect.sv
module sar_fall_detect (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic fall
);
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= din;
  end

  assign fall = prevLvl & ~din;
endmodule

// File: rtl/sar_control.sv
module sar_control
  import sar_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int N_MID = 10,
  parameter int N_LOW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fall,
  input  logic       extClkMode,
  input  logic [1:0] resSel,
  output logic       busy,
  output logic       done,
  output sarStrobe_t strb
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] stepsLeft;
  logic [CW-1:0] nSel;
  logic          stepEn;
  logic          startNow;
  logic          decideNow;
  logic          lastStep;

  always_comb begin
    case (resSel)
      2'b01:   nSel = CW'(N_MID);
      2'b10:   nSel = CW'(N_LOW);
      default: nSel = CW'(WIDTH);
    endcase
  end

  // internal clock: every edge is a step; external: only start falling edges
  assign stepEn    = extClkMode ? fall : 1'b1;
  assign startNow  = fall & (~extClkMode | ~busy);
  assign decideNow = busy & stepEn & ~startNow;
  assign lastStep  = (stepsLeft == CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      stepsLeft <= '0;
    end else begin
      done <= decideNow & lastStep;
      if (startNow) begin
        busy      <= 1'b1;
        stepsLeft <= nSel;
      end else if (decideNow) begin
        stepsLeft <= stepsLeft - CW'(1);
        if (lastStep) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.start  = startNow;
    strb.decide = decideNow;
    strb.last   = lastStep;
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strb,
  input  logic             cmpHigh,
  input  logic             bipolar,
  input  logic             twosComp,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             serData,
  output logic             serClk
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialMask;
  logic [WIDTH-1:0] nextCode;
  logic [WIDTH-1:0] lowerMask;

  assign lowerMask = trialMask >> 1;

  always_comb begin
    nextCode = dacCode & ~trialMask;
    if (cmpHigh)    nextCode = nextCode | trialMask;
    if (!strb.last) nextCode = nextCode | lowerMask;
  end

  function automatic logic [WIDTH-1:0] encode(input logic [WIDTH-1:0] raw,
                                              input logic bip, input logic tc);
    logic [WIDTH-1:0] r;
    r = ~raw;
    if (bip && tc) r[WIDTH-1] = raw[WIDTH-1];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      trialMask <= '0;
      result    <= '0;
      serData   <= 1'b0;
      serClk    <= 1'b0;
    end else begin
      serClk <= 1'b0;
      if (strb.start) begin
        dacCode   <= TOP_BIT;
        trialMask <= TOP_BIT;
      end else if (strb.decide) begin
        dacCode   <= nextCode;
        trialMask <= lowerMask;
        serData   <= ~cmpHigh;
        serClk    <= 1'b1;
        if (strb.last) result <= encode(nextCode, bipolar, twosComp);
      end
    end
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int N_MID = 10,
  parameter int N_LOW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startN,
  input  logic             extClkMode,
  input  logic [1:0]       resSel,
  input  logic             bipolar,
  input  logic             twosComp,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             serData,
  output logic             serClk
);
  logic       startFall;
  sarStrobe_t strb;

  sar_fall_detect u_fall (
    .clk  (clk),
    .rstN (rstN),
    .din  (startN),
    .fall (startFall)
  );

  sar_control #(.WIDTH(WIDTH), .N_MID(N_MID), .N_LOW(N_LOW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fall       (startFall),
    .extClkMode (extClkMode),
    .resSel     (resSel),
    .busy       (busy),
    .done       (done),
    .strb       (strb)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmpHigh  (cmpHigh),
    .bipolar  (bipolar),
    .twosComp (twosComp),
    .dacCode  (dacCode),
    .result   (result),
    .serData  (serData),
    .serClk   (serClk)
  );
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             startN,
  input logic             extClkMode,
  input logic [WIDTH-1:0] dacCode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic             serClk
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic startPrevChk;
  logic fallChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPrevChk <= 1'b1;
    else       startPrevChk <= startN;
  end
  assign fallChk = startPrevChk & ~startN;

  // R1: internal mode restart loads the top trial bit
  a_r1_restart: assert property (@(posedge clk) disable iff (!rstN)
    (!extClkMode && fallChk) |=> (busy && dacCode == TOP_BIT));

  // R3: busy falling edge coincides with done
  a_r3_done_with_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3: done lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: result changes only with done
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R8: serial strobe only follows a busy cycle
  a_r8_serclk_step: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $past(busy));

  // R9: external mode holds the trial code without a start edge
  a_r9_ext_hold: assert property (@(posedge clk) disable iff (!rstN)
    (extClkMode && busy && !fallChk) |=> $stable(dacCode));
endmodule

bind sar_sequencer sar_sequencer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startN     (startN),
  .extClkMode (extClkMode),
  .dacCode    (dacCode),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .serClk     (serClk)
);

// File: tb/sim_sar_sequencer.sv
`timescale 1ns/1ps
module sim_sar_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startN = 1'b1;
  logic        extClkMode = 1'b0;
  logic [1:0]  resSel = 2'b00;
  logic        bipolar = 1'b0;
  logic        twosComp = 1'b0;
  logic        cmpHigh;
  logic [11:0] dacCode;
  logic        busy;
  logic        done;
  logic [11:0] result;
  logic        serData;
  logic        serClk;
  logic [11:0] vin = 12'h000;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [11:0] code;
    int          nBits;
    logic [11:0] serial;
    bit          chkBusy;
    bit          chkSer;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  assign cmpHigh = (vin >= dacCode);

  sar_sequencer u0 (
    .clk(clk), .rstN(rstN), .startN(startN), .extClkMode(extClkMode),
    .resSel(resSel), .bipolar(bipolar), .twosComp(twosComp), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .busy(busy), .done(done), .result(result),
    .serData(serData), .serClk(serClk)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] rs);
    case (rs)
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 12;
    endcase
  endfunction

  function automatic logic [11:0] topMask(input int n);
    return 12'((13'h1000 - (13'h1 << (12 - n))));
  endfunction

  function automatic expItem_t makeItem(input logic [11:0] v, input logic [1:0] rs,
                                        input logic bip, input logic tc);
    expItem_t it;
    logic [11:0] raw;
    int n;
    n = bitsOf(rs);
    raw = v & topMask(n);
    it.code = ~raw;
    if (bip && tc) it.code[11] = raw[11];
    it.nBits = n;
    it.serial = (~raw) >> (12 - n);
    it.chkBusy = 1'b1;
    it.chkSer = 1'b1;
    return it;
  endfunction

  // one-cycle low start pulse; checks the restart trial code (R1)
  task automatic startPulse(input bit chk);
    @(negedge clk); #1 startN = 1'b0;
    @(negedge clk);
    if (chk) check(dacCode == 12'h800 && busy, "R1 restart trial code", dacCode, 12'h800);
    #1 startN = 1'b1;
  endtask

  task automatic convInt(input logic [11:0] v, input logic [1:0] rs,
                         input logic bip, input logic tc);
    expItem_t it;
    @(negedge clk); #1;
    extClkMode = 1'b0; resSel = rs; bipolar = bip; twosComp = tc; vin = v;
    it = makeItem(v, rs, bip, tc);
    expQ.push_back(it);
    startPulse(1'b1);
    repeat (it.nBits + 4) @(negedge clk);
  endtask

  task automatic convExt(input logic [11:0] v, input logic [1:0] rs,
                         input logic bip, input logic tc);
    expItem_t it;
    @(negedge clk); #1;
    extClkMode = 1'b1; resSel = rs; bipolar = bip; twosComp = tc; vin = v;
    it = makeItem(v, rs, bip, tc);
    it.chkBusy = 1'b0;
    expQ.push_back(it);
    startPulse(1'b1);
    repeat (3) @(negedge clk);
    check(dacCode == 12'h800, "R9 hold without start edge", dacCode, 12'h800);
    for (int i = 0; i < it.nBits; i++) begin
      startPulse(1'b0);
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    #1 extClkMode = 1'b0;
  endtask

  // monitor / scoreboard
  int          busyCnt = 0;
  int          serCnt = 0;
  logic [11:0] serAcc = '0;
  logic        doneLast = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      expItem_t it;
      if (busy) busyCnt++;
      if (serClk) begin
        serAcc = {serAcc[10:0], serData};
        serCnt++;
      end
      if (done && doneLast) check(1'b0, "R3 done longer than one cycle", 1, 0);
      if (done) begin
        check(!busy, "R3 busy low with done", busy, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected done", 1, 0);
        end else begin
          it = expQ.pop_front();
          check(result == it.code, "R4 R5 R6 R7 result", result, it.code);
          if (it.chkBusy)
            check(busyCnt == it.nBits, "R2 busy periods", busyCnt, it.nBits);
          if (it.chkSer) begin
            check(serCnt == it.nBits, "R8 serial pulse count", serCnt, it.nBits);
            check((serAcc & ((12'h1 << it.nBits) - 12'h1)) == it.serial,
                  "R8 serial word", serAcc, it.serial);
          end
        end
        busyCnt = 0; serCnt = 0; serAcc = '0;
      end
      doneLast = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] held;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 reset busy", busy, 0);
    check(done == 1'b0, "R3 reset done", done, 0);
    check(result == 12'h000, "R10 reset result", result, 0);
    check(dacCode == 12'h000, "R1 reset trial code", dacCode, 0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);

    convInt(12'hA5C, 2'b00, 1'b0, 1'b0);   // R4 full 12 bits unipolar
    convInt(12'hFFF, 2'b11, 1'b0, 1'b0);   // R5 code 11 is 12 bits
    convInt(12'h000, 2'b00, 1'b0, 1'b0);
    convInt(12'h3C7, 2'b01, 1'b0, 1'b0);   // R5 R6 10 bits
    convInt(12'h9E3, 2'b10, 1'b0, 1'b0);   // R5 R6 8 bits
    convInt(12'h9E3, 2'b00, 1'b1, 1'b0);   // R7 offset binary
    convInt(12'h9E3, 2'b00, 1'b1, 1'b1);   // R7 two's complement
    convInt(12'h234, 2'b10, 1'b1, 1'b1);
    convInt(12'h234, 2'b00, 1'b0, 1'b1);   // R7 twosComp ignored unipolar

    // R1 R10: restart mid-conversion, result held until new done
    held = result;
    @(negedge clk); #1;
    vin = 12'h777; resSel = 2'b00; bipolar = 1'b0; twosComp = 1'b0;
    startPulse(1'b1);
    repeat (4) @(negedge clk);
    begin
      expItem_t it;
      it = makeItem(12'h5A1, 2'b00, 1'b0, 1'b0);
      it.chkBusy = 1'b0; it.chkSer = 1'b0;
      expQ.push_back(it);
    end
    #1 vin = 12'h5A1;
    startPulse(1'b1);
    check(result == held, "R10 result held during restart", result, held);
    repeat (5) @(negedge clk);
    check(result == held, "R10 result held mid conversion", result, held);
    repeat (12) @(negedge clk);

    convExt(12'hC3A, 2'b00, 1'b0, 1'b0);   // R9 external clock 12 bits
    convExt(12'h6B5, 2'b10, 1'b1, 1'b1);   // R9 external clock 8 bits
    convInt(12'h801, 2'b01, 1'b1, 1'b0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R3 all conversions completed", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule